// File: doc/BRIEF.md
# Port Mode and Data Register File for a 28-Port I/O Expander

This block stores the per-port state of a general-purpose I/O expander with 28 ports, numbered 4 to 31. Every port has a two-bit mode (push-pull output, input, input with pullup) and one data bit. A command decoder upstream presents decoded register writes and reads, each carrying a 7-bit address and a data byte. The block turns the stored state into registered output-enable, output-value and pullup-enable vectors for the pad ring. It also registers the incoming pin levels so that reads can return them.

Port data is reached in two ways. A single-port address touches exactly one port. A window address touches eight consecutive ports starting at any port number, with no alignment, and any part of the window that runs past port 31 is dropped. A configuration register carries a run bit. While that bit is clear the block is in shutdown: every port is released to input with its pullup off, but the stored modes and data stay as they are and return when the run bit is set. Reset clears every register, so the block comes up in shutdown with all ports as inputs.

Top module: `gpio_port_regfile`

## Requirements
- R1: After reset every register reads 0x00, so the block is in shutdown and oe, out_val and pu_en are all zero.
- R2: Mode encoding per port is 2'b01 = push-pull output driving its data bit (oe=1), 2'b10 = input without pullup, 2'b11 = input with pullup (pu_en=1), and 2'b00 behaves as input without pullup; out_val is 1 only where oe is 1 and the data bit is 1.
- R3: Mode registers sit at 0x09 to 0x0F, four ports each in ascending order from bit 1:0 (0x09 holds ports 4..7, 0x0F holds ports 28..31), and read back as written.
- R4: The configuration register at 0x04 keeps bit 0 (run; 0 = shutdown) and bit 7 (monitor enable) and reads back as {bit7, 6'b0, bit0}.
- R5: While run is 0, oe and pu_en are zero for every port, and stored modes and data are unchanged, so setting run again restores the previous drive.
- R6: Address 0x20+n (n = 4..31) is a single-port access: a write loads data bit n from wdata[0] and leaves all other ports alone; a read returns the port's value in bit 0 with bits 7:1 zero.
- R7: Address 0x40+n (n = 4..31) is an eight-port window: wdata bit k writes port n+k and read bit k returns port n+k, for any n.
- R8: Window bits that fall on port numbers above 31 are ignored on write and read as 0.
- R9: A port's read value is its stored data bit when its mode is output and run is 1, and otherwise the registered pin level.
- R10: Writes to any other address change nothing, and reads of any other address return 0x00.
- R11: oe, out_val and pu_en change on the clock edge after the one that stores a write; rdata is loaded on the edge that samples rd_en; pin_in passes through one register stage before it can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, held until the next read |
| pin_in | input | 28 | Pin levels, bit 0 = port 4 |
| oe | output | 28 | Output enable per port, bit 0 = port 4 |
| out_val | output | 28 | Output level per port |
| pu_en | output | 28 | Pullup enable per port |

## Verification
The bench aims at the window addresses near the top of the port range, where a design that wraps or clamps the index would alter low ports or return garbage instead of zeros. It toggles the run bit with outputs programmed, which catches a design that clears the stored modes on shutdown or leaves pullups on. Reads in input and output modes with pins set opposite to the data bit expose a design that picks the wrong read source, and writes to unimplemented and neighbouring addresses (port 0 to 3 singles and windows, 0x08, 0x10) catch over-wide decodes.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  typedef enum logic [1:0] {
    MODE_RSVD  = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN    = 2'b10,
    MODE_IN_PU = 2'b11
  } port_mode_e;

  localparam int CFG_ADDR    = 'h04;
  localparam int MODE_GROUP  = 'h08; // mode register of ports 0..3 (absent)
  localparam int SINGLE_BASE = 'h20; // single port n at SINGLE_BASE + n
  localparam int WIN_BASE    = 'h40; // window from port n at WIN_BASE + n
  localparam int CFG_RUN_BIT = 0;
  localparam int CFG_MON_BIT = 7;
endpackage

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
  import gpio_rf_pkg::*;
#(
  parameter int NPORT      = 28,
  parameter int FIRST_PORT = 4,
  parameter int AW         = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  output logic [2*NPORT-1:0] mode_flat,
  output logic [7:0]         rd_byte,
  output logic               hit
);
  localparam int NREG      = NPORT / 4;
  localparam int MODE_BASE = MODE_GROUP + FIRST_PORT / 4;

  logic [1:0]    mode_q [NPORT];
  logic [AW-1:0] reg_idx;

  assign hit     = (int'(addr) >= MODE_BASE) && (int'(addr) < MODE_BASE + NREG);
  assign reg_idx = addr - AW'(MODE_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPORT; p++) mode_q[p] <= MODE_RSVD;
    end else if (wr_en && hit) begin
      for (int p = 0; p < NPORT; p++)
        if (reg_idx == AW'(p / 4)) mode_q[p] <= wdata[2*(p%4) +: 2];
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int p = 0; p < NPORT; p++)
      if (reg_idx == AW'(p / 4)) rd_byte[2*(p%4) +: 2] = mode_q[p];
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_flat
    assign mode_flat[2*g +: 2] = mode_q[g];
  end

  // R10: modes move only on a write that decodes to this bank
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && hit)) |=> $stable(mode_flat));
endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
  import gpio_rf_pkg::*;
#(
  parameter int NPORT      = 28,
  parameter int FIRST_PORT = 4,
  parameter int AW         = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic [NPORT-1:0] rd_src,
  output logic [NPORT-1:0] data_q,
  output logic [7:0]       rd_byte,
  output logic             hit
);
  localparam int S_LO = SINGLE_BASE + FIRST_PORT;
  localparam int W_LO = WIN_BASE + FIRST_PORT;

  logic             single_hit, win_hit;
  logic [AW-1:0]    single_idx, win_start;
  logic [NPORT-1:0] wr_sel, wr_bit;
  logic [7:0]       win_rd;

  assign single_hit = (int'(addr) >= S_LO) && (int'(addr) < S_LO + NPORT);
  assign win_hit    = (int'(addr) >= W_LO) && (int'(addr) < W_LO + NPORT);
  assign hit        = single_hit || win_hit;
  assign single_idx = addr - AW'(S_LO);
  assign win_start  = addr - AW'(W_LO);

  // Port p is covered by window bit k when start + k == p; bits past the
  // last port have no port to land on and fall away.
  always_comb begin
    wr_sel = '0;
    wr_bit = '0;
    win_rd = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (single_hit && single_idx == AW'(p)) begin
        wr_sel[p] = 1'b1;
        wr_bit[p] = wdata[0];
      end
      for (int k = 0; k < 8; k++) begin
        if (k <= p && win_start == AW'(p - k)) begin
          if (win_hit) begin
            wr_sel[p] = 1'b1;
            wr_bit[p] = wdata[k];
          end
          win_rd[k] = rd_src[p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else if (wr_en) data_q <= (data_q & ~wr_sel) | (wr_bit & wr_sel);
  end

  always_comb begin
    rd_byte = '0;
    if (single_hit) rd_byte[0] = rd_src[single_idx[$clog2(NPORT)-1:0]];
    else if (win_hit) rd_byte = win_rd;
  end

  // R10: data bits hold when nothing is written
  a_r10_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(data_q));
  // R6: a single-port write changes at most one bit
  a_r6_single_one_bit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && single_hit) |=> ($countones(data_q ^ $past(data_q)) <= 1));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_rf_pkg::*;
#(
  parameter int NPORT = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shutdown,
  input  logic [2*NPORT-1:0] mode_flat,
  input  logic [NPORT-1:0]   data_q,
  output logic [NPORT-1:0]   oe,
  output logic [NPORT-1:0]   out_val,
  output logic [NPORT-1:0]   pu_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe      <= '0;
      out_val <= '0;
      pu_en   <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        oe[p]      <= !shutdown && (mode_flat[2*p +: 2] == MODE_OUT);
        out_val[p] <= !shutdown && (mode_flat[2*p +: 2] == MODE_OUT) && data_q[p];
        pu_en[p]   <= !shutdown && (mode_flat[2*p +: 2] == MODE_IN_PU);
      end
    end
  end

  // R5: a cycle spent in shutdown leaves no driver or pullup on
  a_r5_shutdown_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(shutdown) |-> (oe == '0 && pu_en == '0));
  // R2: a port never drives and pulls up at once
  a_r2_oe_pu_exclusive: assert property (@(posedge clk) disable iff (rst)
    (oe & pu_en) == '0);
  // R2: a high level appears only on a driving port
  a_r2_val_needs_oe: assert property (@(posedge clk) disable iff (rst)
    (out_val & ~oe) == '0);
endmodule

// File: rtl/gpio_port_regfile.sv
module gpio_port_regfile
  import gpio_rf_pkg::*;
#(
  parameter int NPORT      = 28,
  parameter int FIRST_PORT = 4,
  parameter int AW         = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [NPORT-1:0] pin_in,
  output logic [NPORT-1:0] oe,
  output logic [NPORT-1:0] out_val,
  output logic [NPORT-1:0] pu_en
);
  logic               run_q, mon_q, cfg_hit, shutdown;
  logic [NPORT-1:0]   pin_q, data_q, rd_src;
  logic [2*NPORT-1:0] mode_flat;
  logic [7:0]         mode_rd, data_rd;
  logic               mode_hit, data_hit;

  assign cfg_hit  = (int'(addr) == CFG_ADDR);
  assign shutdown = !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      mon_q <= 1'b0;
      pin_q <= '0;
    end else begin
      pin_q <= pin_in;
      if (wr_en && cfg_hit) begin
        run_q <= wdata[CFG_RUN_BIT];
        mon_q <= wdata[CFG_MON_BIT];
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_src
    assign rd_src[g] = (!shutdown && mode_flat[2*g +: 2] == MODE_OUT) ? data_q[g] : pin_q[g];
  end

  gpio_mode_bank #(.NPORT(NPORT), .FIRST_PORT(FIRST_PORT), .AW(AW)) u_modes (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_flat(mode_flat), .rd_byte(mode_rd), .hit(mode_hit)
  );

  gpio_data_bank #(.NPORT(NPORT), .FIRST_PORT(FIRST_PORT), .AW(AW)) u_data (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_src(rd_src), .data_q(data_q), .rd_byte(data_rd), .hit(data_hit)
  );

  gpio_pin_drive #(.NPORT(NPORT)) u_drive (
    .clk(clk), .rst(rst), .shutdown(shutdown), .mode_flat(mode_flat),
    .data_q(data_q), .oe(oe), .out_val(out_val), .pu_en(pu_en)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      if (cfg_hit)       rdata <= {mon_q, 6'b0, run_q};
      else if (mode_hit) rdata <= mode_rd;
      else if (data_hit) rdata <= data_rd;
      else               rdata <= 8'h00;
    end
  end

  // R11: rdata holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rdata));
  // R4: run bit changes only through a configuration write
  a_r4_run_write_only: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && cfg_hit)) |=> $stable(run_q));
endmodule

// File: tb/gpio_port_regfile_tb.sv
module gpio_port_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 28;

  logic          clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [6:0]    addr = '0;
  logic [7:0]    wdata = '0, rdata;
  logic [NP-1:0] pin_in = '0, oe, out_val, pu_en;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0]    mmode [NP];
  logic          mdata [NP];
  logic          mrun, mmon;
  logic [NP-1:0] mpin;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regfile u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .oe(oe),
    .out_val(out_val), .pu_en(pu_en)
  );

  function automatic logic src(int p);
    return (mrun && mmode[p] == 2'b01) ? mdata[p] : mpin[p];
  endfunction

  function automatic logic [7:0] exp_read(logic [6:0] a);
    logic [7:0] r = 8'h00;
    int ai = int'(a);
    if (ai == 4) r = {mmon, 6'b0, mrun};
    else if (ai >= 9 && ai <= 15)
      for (int j = 0; j < 4; j++) r[2*j +: 2] = mmode[(ai-9)*4 + j];
    else if (ai >= 'h24 && ai <= 'h3F) r[0] = src(ai - 'h24);
    else if (ai >= 'h44 && ai <= 'h5F)
      for (int k = 0; k < 8; k++) if (ai - 'h44 + k < NP) r[k] = src(ai - 'h44 + k);
    return r;
  endfunction

  task automatic model_write(logic [6:0] a, logic [7:0] d);
    int ai = int'(a);
    if (ai == 4) begin mrun = d[0]; mmon = d[7]; end
    else if (ai >= 9 && ai <= 15)
      for (int j = 0; j < 4; j++) mmode[(ai-9)*4 + j] = d[2*j +: 2];
    else if (ai >= 'h24 && ai <= 'h3F) mdata[ai - 'h24] = d[0];
    else if (ai >= 'h44 && ai <= 'h5F)
      for (int k = 0; k < 8; k++) if (ai - 'h44 + k < NP) mdata[ai - 'h44 + k] = d[k];
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    model_write(a, d);
    @(negedge clk); // R11: drive outputs settle one edge after the store
  endtask

  task automatic rd_chk(string req, logic [6:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(req, $sformatf("read 0x%02h", a), 32'(rdata), 32'(exp_read(a)));
  endtask

  task automatic set_pins(logic [NP-1:0] v);
    @(negedge clk); pin_in = v; mpin = v;
    @(negedge clk); // R11: one register stage on the pins
  endtask

  task automatic chk_outs(string req);
    logic [NP-1:0] e_oe, e_val, e_pu;
    for (int p = 0; p < NP; p++) begin
      e_oe[p]  = mrun && mmode[p] == 2'b01;
      e_val[p] = e_oe[p] && mdata[p];
      e_pu[p]  = mrun && mmode[p] == 2'b11;
    end
    chk(req, "oe", 32'(oe), 32'(e_oe));
    chk(req, "out_val", 32'(out_val), 32'(e_val));
    chk(req, "pu_en", 32'(pu_en), 32'(e_pu));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin mmode[p] = 2'b00; mdata[p] = 0; end
    mrun = 0; mmon = 0; mpin = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk_outs("R1");
    rd_chk("R1", 7'h04);
    rd_chk("R1", 7'h09);
    rd_chk("R1", 7'h0F);

    // R3: mode layout; R5 shutdown still holds with run=0
    wr(7'h09, 8'h55); wr(7'h0F, 8'hE4);
    rd_chk("R3", 7'h09); rd_chk("R3", 7'h0F);
    chk_outs("R5");
    // R4: config readback with unused bits masked
    wr(7'h04, 8'hFF); rd_chk("R4", 7'h04);
    chk_outs("R2");
    // R6: single port set and clear on port 4 and port 31
    wr(7'h24, 8'h01); chk_outs("R6"); rd_chk("R6", 7'h24);
    wr(7'h3F, 8'hFE); rd_chk("R6", 7'h3F);
    // all outputs, then window near the top: R7, R8
    for (int r = 9; r <= 15; r++) wr(7'(r), 8'h55);
    wr(7'h5D, 8'hFF); chk_outs("R8"); rd_chk("R8", 7'h5D);
    wr(7'h47, 8'hA5); chk_outs("R7"); rd_chk("R7", 7'h47); rd_chk("R7", 7'h49);
    // R5: shutdown releases but keeps state, restore after
    set_pins(28'h0F0F0F0);
    wr(7'h04, 8'h00); chk_outs("R5"); rd_chk("R9", 7'h47);
    wr(7'h04, 8'h01); chk_outs("R5");
    // R9: input ports return pins even with data set
    wr(7'h0B, 8'hAA); set_pins(28'h5A5A5A5);
    rd_chk("R9", 7'h4C); rd_chk("R9", 7'h2C); rd_chk("R9", 7'h24);
    // R10: unimplemented addresses
    wr(7'h10, 8'hFF); wr(7'h08, 8'hFF); wr(7'h23, 8'h01); wr(7'h40, 8'hFF);
    chk_outs("R10");
    rd_chk("R10", 7'h10); rd_chk("R10", 7'h08); rd_chk("R10", 7'h43); rd_chk("R10", 7'h7F);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [6:0] a;
      logic [7:0] d = 8'($urandom);
      case ($urandom % 6)
        0: begin a = 7'h04; d[0] = ($urandom % 4) != 0; end
        1: a = 7'(9 + $urandom % 7);
        2: a = 7'('h24 + $urandom % 28);
        3: a = 7'('h44 + $urandom % 28);
        default: a = 7'($urandom);
      endcase
      if ($urandom % 3 == 0) set_pins(28'($urandom));
      if ($urandom % 2 == 0) begin wr(a, d); chk_outs("R2"); end
      else rd_chk("R9", a);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule